// File: doc/BRIEF.md
# Bus-Master DMA Write Engine

This block moves 32-bit words from an add-on agent onto a shared parallel bus as bus master. The add-on side pushes words into an eight-entry write FIFO. Whenever mastering is enabled and the FIFO holds data, the engine raises a bus request. When it sees the grant while the bus is idle, it runs one address phase carrying the current write address. Data phases follow, one word each, drawn from the FIFO in order.

A burst ends when the FIFO runs dry, or when the target answers a data phase with retry. After a retry the word stays queued and the address does not advance. The engine then drops its request for a fixed back-off and asks for the bus again. The new tenure opens at the address just after the last word the target took. An optional down-counter can end the whole transfer after a programmed number of words. A constant field reports the bus access interval the block needs, in 250 ns units.

Top module: `dmaw_engine`

## Requirements
- R1: While reset is held, `bus_req`, `fifo_full` and `xfer_done` are 0, and `fifo_level` and `stall_cnt` are 0.
- R2: The FIFO holds 8 words and `fifo_level` reports 0 to 8. `fifo_full` is 1 at level 8. A push presented while `fifo_full` is 1 is discarded, even if a word leaves in the same cycle, and adds 1 to `stall_cnt`.
- R3: `bus_req` is 1 only while `cfg_master_en` is 1 and the FIFO is non-empty. With `cfg_master_en` at 0, no request is made whatever the FIFO holds.
- R4: The cycle after the engine sees `bus_gnt` and `bus_idle` both 1 while requesting, it drives `bus_aphase` for exactly one cycle with `bus_ad` set to the current write address. Data phases follow.
- R5: During a data phase (`bus_dphase`=1), `bus_ad` carries the oldest FIFO word. A phase with `tgt_retry`=0 is complete: the word leaves the FIFO and the write address grows by 4.
- R6: A data phase with `tgt_retry`=1 moves nothing. The word stays at the FIFO head, the address is unchanged, and the tenure ends.
- R7: After a retry, `bus_req` is 0 for exactly 2 cycles and then returns if data is pending. The next address phase carries the address following the last completed word, for example 0x100010 after four words from 0x100000.
- R8: When the FIFO empties during a burst, the request drops. Later data opens a new tenure whose address phase continues the address sequence.
- R9: With `cfg_cnt_en`=0, words keep flowing for as long as data arrives, with no count limit.
- R10: With `cfg_cnt_en`=1, each completed word decrements the count. When it reaches 0, `xfer_done` goes to 1 and requests stop with data still queued. Loading a new count clears `xfer_done` and resumes the transfer.
- R11: `lat_info` reports the `MAX_LAT_UNITS` parameter in units of 250 ns. The default is 0, meaning no requirement.
- R12: A grant seen while `bus_idle` is 0 starts no address phase. The engine keeps requesting until the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master_en | input | 1 | Allows bus mastering |
| cfg_addr_load | input | 1 | Loads the write address (taken while not in a tenure) |
| cfg_addr_val | input | 32 | Start byte address |
| cfg_cnt_en | input | 1 | Enables count-based termination |
| cfg_cnt_load | input | 1 | Loads the word count (taken while idle or done) |
| cfg_cnt_val | input | CNT_W | Word count to transfer |
| push_valid | input | 1 | Add-on push strobe |
| push_data | input | 32 | Word to queue |
| fifo_full | output | 1 | FIFO holds 8 words |
| fifo_level | output | LVL_W | Words queued |
| stall_cnt | output | STALL_W | Pushes refused because the FIFO was full |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_idle | input | 1 | Bus free of other traffic |
| bus_aphase | output | 1 | Address phase in progress |
| bus_dphase | output | 1 | Data phase in progress |
| bus_ad | output | 32 | Address or data driven on the bus |
| tgt_retry | input | 1 | Target refuses the current data phase |
| xfer_done | output | 1 | Programmed count exhausted |
| lat_info | output | 8 | Access interval in 250 ns units, read-only |

## Verification
The hardest case to reach is a retry in the middle of a burst that still has queued words. Only then can the back-off length and the resumed address be observed together. The bench fills the FIFO with mastering disabled and then enables it, so the first tenure is long. Its target model counts the data phases in each tenure and answers the fifth one with retry. The monitor then measures how long the request stays low and checks the address phase that follows. The count limit is driven the same way: the bench preloads more words than the count allows, so `xfer_done` must appear while the FIFO is still non-empty.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_BACKOFF,
        ST_DONE
    } seq_state_e;

    localparam int unsigned BYTES_PER_WORD = 4;

endpackage

// File: rtl/dmaw_fifo.sv
module dmaw_fifo #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned DW      = 32,
    parameter int unsigned STALL_W = 16,
    parameter int unsigned LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [DW-1:0]      push_data,
    input  logic               pop,
    output logic [DW-1:0]      head,
    output logic [LVL_W-1:0]   level,
    output logic               full,
    output logic               empty,
    output logic [STALL_W-1:0] stall_cnt
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]   wr;
        logic [PTR_W-1:0]   rd;
        logic [LVL_W-1:0]   lvl;
        logic [STALL_W-1:0] stall;
    } fifo_st_t;

    fifo_st_t       s_d, s_q;
    logic [DW-1:0]  mem_q [DEPTH];
    logic           accept;

    // pointer advance, wrap chosen by whether DEPTH is a power of two
    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if ((DEPTH & (DEPTH - 1)) == 0) begin
            return p + 1'b1;
        end else begin
            return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
        end
    endfunction

    always_comb begin
        s_d    = s_q;
        full   = (s_q.lvl == LVL_W'(DEPTH));
        empty  = (s_q.lvl == '0);
        accept = push_valid && !full;
        if (accept) begin
            s_d.wr = ptr_next(s_q.wr);
        end
        if (pop) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        if (push_valid && full) begin
            s_d.stall = s_q.stall + 1'b1;
        end
        s_d.lvl = s_q.lvl + LVL_W'(accept) - LVL_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[s_q.wr] <= push_data;
        end
    end

    assign head      = mem_q[s_q.rd];
    assign level     = s_q.lvl;
    assign stall_cnt = s_q.stall;

endmodule

// File: rtl/dmaw_seq.sv
module dmaw_seq
    import dmaw_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned BACKOFF_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic             addr_load,
    input  logic [AW-1:0]    addr_val,
    input  logic             cnt_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             fifo_empty,
    input  logic             bus_gnt,
    input  logic             bus_idle,
    input  logic             tgt_retry,
    output logic             bus_req,
    output logic             bus_aphase,
    output logic             bus_dphase,
    output logic [AW-1:0]    cur_addr,
    output logic             pop,
    output logic             done
);

    localparam int unsigned BO_W = (BACKOFF_CLKS > 1) ? $clog2(BACKOFF_CLKS) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [AW-1:0]     addr;
        logic [CNT_W-1:0]  cnt;
        logic [BO_W-1:0]   bo;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    have_data;
    logic    cnt_spent;

    always_comb begin
        s_d        = s_q;
        bus_req    = 1'b0;
        bus_aphase = 1'b0;
        bus_dphase = 1'b0;
        pop        = 1'b0;
        have_data  = master_en && !fifo_empty;
        cnt_spent  = cnt_en && (s_q.cnt == '0);

        unique case (s_q.state)
            ST_IDLE: begin
                if (addr_load) s_d.addr = addr_val;
                if (cnt_load)  s_d.cnt  = cnt_val;
                if (have_data && !cnt_spent) s_d.state = ST_REQ;
            end
            ST_REQ: begin
                bus_req = have_data;
                if (!have_data) begin
                    s_d.state = ST_IDLE;
                end else if (bus_gnt && bus_idle) begin
                    s_d.state = ST_ADDR;
                end
            end
            ST_ADDR: begin
                bus_req = have_data;
                if (!have_data) begin
                    s_d.state = ST_IDLE;
                end else begin
                    bus_aphase = 1'b1;
                    s_d.state  = ST_DATA;
                end
            end
            ST_DATA: begin
                bus_req = have_data;
                if (!have_data) begin
                    s_d.state = ST_IDLE;
                end else begin
                    bus_dphase = 1'b1;
                    if (tgt_retry) begin
                        s_d.state = ST_BACKOFF;
                        s_d.bo    = BO_W'(BACKOFF_CLKS - 1);
                    end else begin
                        pop      = 1'b1;
                        s_d.addr = s_q.addr + AW'(BYTES_PER_WORD);
                        if (cnt_en) begin
                            if (s_q.cnt != '0) s_d.cnt = s_q.cnt - 1'b1;
                            if (s_q.cnt <= CNT_W'(1)) s_d.state = ST_DONE;
                        end
                    end
                end
            end
            ST_BACKOFF: begin
                if (s_q.bo == '0) begin
                    s_d.state = have_data ? ST_REQ : ST_IDLE;
                end else begin
                    s_d.bo = s_q.bo - 1'b1;
                end
            end
            ST_DONE: begin
                if (addr_load) s_d.addr = addr_val;
                if (cnt_load)  s_d.cnt  = cnt_val;
                if (cnt_load || !cnt_en) s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_addr = s_q.addr;
    assign done     = (s_q.state == ST_DONE);

endmodule

// File: rtl/dmaw_engine.sv
module dmaw_engine #(
    parameter int unsigned FIFO_DEPTH    = 8,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned STALL_W       = 16,
    parameter int unsigned BACKOFF_CLKS  = 2,
    parameter int unsigned MAX_LAT_UNITS = 0,
    parameter int unsigned LVL_W         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_master_en,
    input  logic               cfg_addr_load,
    input  logic [DATA_W-1:0]  cfg_addr_val,
    input  logic               cfg_cnt_en,
    input  logic               cfg_cnt_load,
    input  logic [CNT_W-1:0]   cfg_cnt_val,
    input  logic               push_valid,
    input  logic [DATA_W-1:0]  push_data,
    output logic               fifo_full,
    output logic [LVL_W-1:0]   fifo_level,
    output logic [STALL_W-1:0] stall_cnt,
    output logic               bus_req,
    input  logic               bus_gnt,
    input  logic               bus_idle,
    output logic               bus_aphase,
    output logic               bus_dphase,
    output logic [DATA_W-1:0]  bus_ad,
    input  logic               tgt_retry,
    output logic               xfer_done,
    output logic [7:0]         lat_info
);

    logic              fifo_pop;
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [DATA_W-1:0] wr_addr;

    dmaw_fifo #(
        .DEPTH   (FIFO_DEPTH),
        .DW      (DATA_W),
        .STALL_W (STALL_W),
        .LVL_W   (LVL_W)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_data  (push_data),
        .pop        (fifo_pop),
        .head       (fifo_head),
        .level      (fifo_level),
        .full       (fifo_full),
        .empty      (fifo_empty),
        .stall_cnt  (stall_cnt)
    );

    dmaw_seq #(
        .AW           (DATA_W),
        .CNT_W        (CNT_W),
        .BACKOFF_CLKS (BACKOFF_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_en  (cfg_master_en),
        .addr_load  (cfg_addr_load),
        .addr_val   (cfg_addr_val),
        .cnt_en     (cfg_cnt_en),
        .cnt_load   (cfg_cnt_load),
        .cnt_val    (cfg_cnt_val),
        .fifo_empty (fifo_empty),
        .bus_gnt    (bus_gnt),
        .bus_idle   (bus_idle),
        .tgt_retry  (tgt_retry),
        .bus_req    (bus_req),
        .bus_aphase (bus_aphase),
        .bus_dphase (bus_dphase),
        .cur_addr   (wr_addr),
        .pop        (fifo_pop),
        .done       (xfer_done)
    );

    always_comb begin
        if (bus_aphase) begin
            bus_ad = wr_addr;
        end else if (bus_dphase) begin
            bus_ad = fifo_head;
        end else begin
            bus_ad = '0;
        end
    end

    assign lat_info = 8'(MAX_LAT_UNITS);

endmodule

// File: rtl/dmaw_engine_chk.sv
module dmaw_engine_chk #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LVL_W   = 4,
    parameter int unsigned STALL_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_master_en,
    input logic               push_valid,
    input logic               fifo_full,
    input logic [LVL_W-1:0]   fifo_level,
    input logic [STALL_W-1:0] stall_cnt,
    input logic               bus_req,
    input logic               bus_gnt,
    input logic               bus_idle,
    input logic               bus_aphase,
    input logic               bus_dphase,
    input logic               tgt_retry,
    input logic               xfer_done
);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R2
    stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && fifo_full |=> stall_cnt == $past(stall_cnt) + 1'b1);

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !bus_dphase |=> fifo_full);

    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cfg_master_en && fifo_level != '0);

    // R4
    aphase_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aphase |-> $past(bus_gnt && bus_idle && bus_req));

    // R4
    aphase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_aphase |=> !bus_aphase);

    // R5
    pop_on_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dphase && !tgt_retry && !push_valid |=> fifo_level == $past(fifo_level) - 1'b1);

    // R6
    retry_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dphase && tgt_retry |=> !bus_req && fifo_level >= $past(fifo_level));

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !bus_req);

endmodule

bind dmaw_engine dmaw_engine_chk #(
    .DEPTH   (FIFO_DEPTH),
    .LVL_W   (LVL_W),
    .STALL_W (STALL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_master_en (cfg_master_en),
    .push_valid    (push_valid),
    .fifo_full     (fifo_full),
    .fifo_level    (fifo_level),
    .stall_cnt     (stall_cnt),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_idle      (bus_idle),
    .bus_aphase    (bus_aphase),
    .bus_dphase    (bus_dphase),
    .tgt_retry     (tgt_retry),
    .xfer_done     (xfer_done)
);

// File: tb/test_dmaw_engine.sv
`timescale 1ns/1ps
module test_dmaw_engine;

    localparam int CLK_PERIOD = 30;
    localparam int GNT_LAT    = 4;
    localparam int CNT_W      = 16;
    localparam int STALL_W    = 16;
    localparam int LVL_W      = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_master_en = 1'b0;
    logic               cfg_addr_load = 1'b0;
    logic [31:0]        cfg_addr_val = '0;
    logic               cfg_cnt_en = 1'b0;
    logic               cfg_cnt_load = 1'b0;
    logic [CNT_W-1:0]   cfg_cnt_val = '0;
    logic               push_valid = 1'b0;
    logic [31:0]        push_data = '0;
    logic               fifo_full;
    logic [LVL_W-1:0]   fifo_level;
    logic [STALL_W-1:0] stall_cnt;
    logic               bus_req;
    logic               bus_gnt = 1'b0;
    logic               bus_idle = 1'b1;
    logic               bus_aphase;
    logic               bus_dphase;
    logic [31:0]        bus_ad;
    logic               tgt_retry = 1'b0;
    logic               xfer_done;
    logic [7:0]         lat_info;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmaw_engine i_dmaw_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_master_en (cfg_master_en),
        .cfg_addr_load (cfg_addr_load),
        .cfg_addr_val  (cfg_addr_val),
        .cfg_cnt_en    (cfg_cnt_en),
        .cfg_cnt_load  (cfg_cnt_load),
        .cfg_cnt_val   (cfg_cnt_val),
        .push_valid    (push_valid),
        .push_data     (push_data),
        .fifo_full     (fifo_full),
        .fifo_level    (fifo_level),
        .stall_cnt     (stall_cnt),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_idle      (bus_idle),
        .bus_aphase    (bus_aphase),
        .bus_dphase    (bus_dphase),
        .bus_ad        (bus_ad),
        .tgt_retry     (tgt_retry),
        .xfer_done     (xfer_done),
        .lat_info      (lat_info)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [31:0] exp_q[$];
    logic [31:0] base_addr = '0;
    int          words_done = 0;
    int          exp_stall = 0;
    int          retry_limit = 0;
    int          phase_in_tenure = 0;
    int          aphase_cnt = 0;
    int          retry_cnt = 0;
    logic [31:0] last_aphase_addr = '0;
    bit          after_retry = 0;
    bit          in_backoff = 0;
    int          bo_low = 0;
    int          gnt_cnt = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor, target model and arbiter, all sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] exp_a;
            exp_a = base_addr + 32'(4 * words_done);
            if (in_backoff) begin
                if (!bus_req) begin
                    bo_low++;
                end else begin
                    check(bo_low == 2, "R7 back-off length", 32'(bo_low), 32'd2);
                    in_backoff = 0;
                end
            end
            if (bus_aphase) begin
                check(bus_ad == exp_a, after_retry ? "R7 resume address" : "R4 address phase",
                      bus_ad, exp_a);
                last_aphase_addr = bus_ad;
                aphase_cnt++;
                phase_in_tenure = 0;
            end
            tgt_retry = 1'b0;
            if (bus_dphase) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected data phase", bus_ad, 32'h0);
                end else begin
                    check(bus_ad == exp_q[0], after_retry ? "R6 retried word" : "R5 data order",
                          bus_ad, exp_q[0]);
                    if (retry_limit != 0 && phase_in_tenure == retry_limit) begin
                        tgt_retry   = 1'b1;
                        retry_cnt++;
                        after_retry = 1;
                        in_backoff  = 1;
                        bo_low      = 0;
                    end else begin
                        void'(exp_q.pop_front());
                        words_done++;
                        phase_in_tenure++;
                        after_retry = 0;
                    end
                end
            end
            if (bus_req) begin
                if (gnt_cnt >= GNT_LAT) bus_gnt = 1'b1;
                else gnt_cnt++;
            end else begin
                bus_gnt = 1'b0;
                gnt_cnt = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] d);
        @(negedge clk);
        if (!fifo_full) exp_q.push_back(d);
        else exp_stall++;
        push_valid = 1'b1;
        push_data  = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic load_addr(input logic [31:0] a);
        @(negedge clk);
        cfg_addr_load = 1'b1;
        cfg_addr_val  = a;
        base_addr     = a - 32'(4 * words_done);
        @(negedge clk);
        cfg_addr_load = 1'b0;
    endtask

    task automatic load_cnt(input logic [CNT_W-1:0] v);
        @(negedge clk);
        cfg_cnt_load = 1'b1;
        cfg_cnt_val  = v;
        @(negedge clk);
        cfg_cnt_load = 1'b0;
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while ((exp_q.size() != 0 || fifo_level != '0) && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(exp_q.size() == 0 && fifo_level == '0, tag, 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        int start_a;
        int guard;
        tick(3);
        // R1 reset state
        check(bus_req == 1'b0, "R1 req in reset", 32'(bus_req), 32'h0);
        check(fifo_level == '0 && fifo_full == 1'b0, "R1 fifo in reset", 32'(fifo_level), 32'h0);
        check(xfer_done == 1'b0, "R1 done in reset", 32'(xfer_done), 32'h0);
        check(stall_cnt == '0, "R1 stall in reset", 32'(stall_cnt), 32'h0);
        // R11 latency field default
        check(lat_info == 8'd0, "R11 latency field", 32'(lat_info), 32'h0);
        rst_n = 1'b1;
        tick(2);

        // R2 / R3: fill with mastering off, ninth push overflows
        load_addr(32'h0010_0000);
        for (int i = 0; i < 9; i++) push_word(32'hA000_0000 + 32'(i));
        tick(4);
        check(fifo_level == 4'd8, "R2 level at capacity", 32'(fifo_level), 32'd8);
        check(fifo_full == 1'b1, "R2 full flag", 32'(fifo_full), 32'd1);
        check(stall_cnt == 16'd1, "R2 refused push counted", 32'(stall_cnt), 32'd1);
        check(exp_q.size() == 8, "R2 ninth word discarded", 32'(exp_q.size()), 32'd8);
        check(bus_req == 1'b0, "R3 no request when disabled", 32'(bus_req), 32'h0);

        // R6 / R7: target takes four phases per tenure
        retry_limit   = 4;
        cfg_master_en = 1'b1;
        drain("R6 burst with retry drains");
        check(retry_cnt == 1, "R6 one retry seen", 32'(retry_cnt), 32'd1);
        check(last_aphase_addr == 32'h0010_0010, "R7 resumed at next word",
              last_aphase_addr, 32'h0010_0010);
        check(aphase_cnt == 2, "R4 two tenures", 32'(aphase_cnt), 32'd2);
        tick(3);
        check(bus_req == 1'b0, "R8 request drops when empty", 32'(bus_req), 32'h0);

        // R8: new data opens a tenure that continues the address
        cfg_master_en = 1'b0;
        for (int i = 0; i < 3; i++) push_word(32'hB000_0000 + 32'(i));
        cfg_master_en = 1'b1;
        drain("R8 second batch drains");
        check(last_aphase_addr == 32'h0010_0020, "R8 continued address",
              last_aphase_addr, 32'h0010_0020);
        check(aphase_cnt == 3, "R8 new tenure", 32'(aphase_cnt), 32'd3);

        // R9: no count limit, data keeps arriving during the burst
        retry_limit   = 0;
        cfg_master_en = 1'b0;
        load_addr(32'h0030_0000);
        for (int i = 0; i < 8; i++) push_word(32'hC000_0000 + 32'(i));
        start_a       = aphase_cnt;
        cfg_master_en = 1'b1;
        guard = 0;
        while (aphase_cnt == start_a && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        for (int i = 8; i < 14; i++) push_word(32'hC000_0000 + 32'(i));
        drain("R9 long transfer drains");
        check(base_addr + 32'(4 * words_done) == 32'h0030_0038, "R9 fourteen words moved",
              base_addr + 32'(4 * words_done), 32'h0030_0038);
        check(stall_cnt == 16'(1 + exp_stall - 1) && exp_stall == 1, "R2 stall total",
              32'(stall_cnt), 32'(exp_stall));

        // R10: count limit stops with data queued, reload resumes
        cfg_master_en = 1'b0;
        cfg_cnt_en    = 1'b1;
        load_addr(32'h0040_0000);
        load_cnt(16'd3);
        for (int i = 0; i < 6; i++) push_word(32'hD000_0000 + 32'(i));
        cfg_master_en = 1'b1;
        guard = 0;
        while (!xfer_done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        tick(3);
        check(xfer_done == 1'b1, "R10 done raised", 32'(xfer_done), 32'd1);
        check(bus_req == 1'b0, "R10 no request when done", 32'(bus_req), 32'h0);
        check(fifo_level == 4'd3, "R10 words left queued", 32'(fifo_level), 32'd3);
        check(base_addr + 32'(4 * words_done) == 32'h0040_000C, "R10 three words moved",
              base_addr + 32'(4 * words_done), 32'h0040_000C);
        load_cnt(16'd5);
        drain("R10 resume after reload");
        check(xfer_done == 1'b0, "R10 done cleared by reload", 32'(xfer_done), 32'h0);
        cfg_cnt_en = 1'b0;

        // R12: grant while bus busy starts nothing
        cfg_master_en = 1'b0;
        bus_idle      = 1'b0;
        for (int i = 0; i < 2; i++) push_word(32'hE000_0000 + 32'(i));
        start_a       = aphase_cnt;
        cfg_master_en = 1'b1;
        tick(12);
        check(bus_req == 1'b1 && bus_gnt == 1'b1, "R12 requesting and granted",
              32'(bus_req), 32'd1);
        check(aphase_cnt == start_a, "R12 no address phase while busy",
              32'(aphase_cnt), 32'(start_a));
        bus_idle = 1'b1;
        drain("R12 drains once idle");
        check(aphase_cnt == start_a + 1, "R12 one tenure after idle",
              32'(aphase_cnt), 32'(start_a + 1));

        tick(4);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule